// File: doc/BRIEF.md
# Egress Guard for a Cryptographic Output Port

This block stands between the result stream of a cryptographic core and the external data output of the module. Every cycle it decides whether a result word may leave. Five module-wide conditions shut the path completely: a fault, a running self-test, key generation, manual key loading and zeroization. While the path is shut, nothing is lost. The word already held stays in place, and the upstream side sees backpressure until the condition clears.

Each word carries a tag that marks sensitive content, such as a plaintext key. A tagged word is released only after two separate arming strobes arrive in order: arm A, then arm B on a later cycle. The arming lapses after a fixed window, after one tagged word goes out, or as soon as any shut condition appears. The reason for a blocked output is reported only on a separate 3-bit status output, never on the data path. After reset the block stays shut until module control raises a ready indication.

Top module: `egress_guard`

## Requirements
- R1: While `fault_i` is high, `out_valid` and `in_ready` are 0 and `status_code` is 1.
- R2: While `selftest_i` is high, `out_valid` and `in_ready` are 0 and `status_code` is 2, unless a higher-priority condition is active.
- R3: While `keygen_i`, `keyload_i` or `zeroize_i` is high, `out_valid` and `in_ready` are 0, and `status_code` is 3, 4 or 5 respectively.
- R4: When several conditions are active, `status_code` follows the priority fault (1), zeroize (5), self-test (2), key generation (3), key loading (4), startup hold (7).
- R5: No word is dropped, duplicated or reordered. A word held during a shut condition or a stall keeps its value and is delivered after the condition clears.
- R6: A word with `in_sens`=1 is presented only after arm A and then arm B are each captured on their own cycle. While it waits, `status_code` is 6. Arm B is rejected when arm A is not already set, and strobes on both inputs in the same cycle are ignored.
- R7: Releasing one tagged word clears both arm flags, so the next tagged word needs a fresh arming sequence.
- R8: Arm A lasts `ARM_WINDOW` cycles (default 256). Arm B captured after that window is rejected.
- R9: Any shut condition, including startup hold, clears both arm flags.
- R10: After reset, `in_ready` and `out_valid` stay 0 and `status_code` is 7 until `ctl_ready` has been high for one clock edge. That release then holds until the next reset.
- R11: Untagged words pass with one cycle of latency, and `status_code` is 0 whenever a word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_ready | input | 1 | Module control ready indication, releases startup hold |
| fault_i | input | 1 | Module in error state |
| selftest_i | input | 1 | Self-test running |
| keygen_i | input | 1 | Key generation in progress |
| keyload_i | input | 1 | Manual key loading in progress |
| zeroize_i | input | 1 | Key zeroization in progress |
| arm_a_i | input | 1 | First arming strobe |
| arm_b_i | input | 1 | Second arming strobe |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DATA_W | Upstream word |
| in_sens | input | 1 | Word is sensitive (1) |
| out_valid | output | 1 | Output word presented |
| out_ready | input | 1 | Port accepts the word |
| out_data | output | DATA_W | Output word |
| status_code | output | 3 | Blocking reason code |

## Verification
The assertions assume that the upstream side keeps `in_data` and `in_sens` stable while a word is offered. They also assume the mode inputs are plain levels that change only between clock edges. The bench drives every input shortly after the rising edge, so each level holds for a whole cycle. Its random phase sends only untagged words while modes toggle, which keeps arm state out of the random expectations. Tagged words and arming order are covered by directed sequences.

// File: rtl/egress_pkg.sv
package egress_pkg;
    typedef enum logic [2:0] {
        RSN_OPEN     = 3'd0,
        RSN_FAULT    = 3'd1,
        RSN_SELFTEST = 3'd2,
        RSN_KEYGEN   = 3'd3,
        RSN_KEYLOAD  = 3'd4,
        RSN_ZEROIZE  = 3'd5,
        RSN_ARMWAIT  = 3'd6,
        RSN_STARTUP  = 3'd7
    } reason_e;

    typedef struct packed {
        logic fault;
        logic zeroize;
        logic selftest;
        logic keygen;
        logic keyload;
    } mode_t;
endpackage

// File: rtl/egress_hold_buf.sv
module egress_hold_buf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              block_i,
    input  logic              release_ok_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_sens_i,
    output logic              in_ready_o,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              head_sens_o,
    output logic              fire_o
);
    typedef struct packed {
        logic              full;
        logic              sens;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  present;
    logic  take;

    always_comb begin
        present     = slot_q.full && !block_i && (!slot_q.sens || release_ok_i);
        fire_o      = present && out_ready_i;
        in_ready_o  = !block_i && (!slot_q.full || fire_o);
        take        = in_valid_i && in_ready_o;
        out_valid_o = present;
        out_data_o  = slot_q.data;
        head_sens_o = slot_q.full && slot_q.sens;

        slot_d = slot_q;
        if (fire_o) begin
            slot_d.full = 1'b0;
        end
        if (take) begin
            slot_d.full = 1'b1;
            slot_d.sens = in_sens_i;
            slot_d.data = in_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end
endmodule

// File: rtl/egress_arm_ctrl.sv
module egress_arm_ctrl #(
    parameter int ARM_WINDOW = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic consume_i,
    input  logic arm_a_i,
    input  logic arm_b_i,
    output logic arm_a_o,
    output logic arm_b_o,
    output logic armed_o
);
    localparam int TW = $clog2(ARM_WINDOW + 1);
    localparam logic [TW-1:0] LAST = TW'(ARM_WINDOW - 1);

    typedef struct packed {
        logic          a;
        logic          b;
        logic [TW-1:0] age;
    } arm_t;

    arm_t arm_d, arm_q;
    logic expired;
    logic lone_strobe;

    always_comb begin
        expired     = arm_q.a && (arm_q.age == LAST);
        lone_strobe = arm_a_i ^ arm_b_i;
        arm_d       = arm_q;
        if (clear_i || consume_i || expired) begin
            arm_d = '0;
        end else begin
            if (arm_q.a) begin
                arm_d.age = arm_q.age + 1'b1;
            end
            if (lone_strobe) begin
                if (arm_a_i && !arm_q.a) begin
                    arm_d.a   = 1'b1;
                    arm_d.age = '0;
                end
                if (arm_b_i && arm_q.a) begin
                    arm_d.b = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign arm_a_o = arm_q.a;
    assign arm_b_o = arm_q.b;
    assign armed_o = arm_q.a && arm_q.b;
endmodule

// File: rtl/egress_reason_enc.sv
module egress_reason_enc
    import egress_pkg::*;
(
    input  mode_t      mode_i,
    input  logic       startup_i,
    input  logic       arm_wait_i,
    output logic [2:0] reason_o
);
    reason_e r;

    always_comb begin
        if (mode_i.fault)         r = RSN_FAULT;
        else if (mode_i.zeroize)  r = RSN_ZEROIZE;
        else if (mode_i.selftest) r = RSN_SELFTEST;
        else if (mode_i.keygen)   r = RSN_KEYGEN;
        else if (mode_i.keyload)  r = RSN_KEYLOAD;
        else if (startup_i)       r = RSN_STARTUP;
        else if (arm_wait_i)      r = RSN_ARMWAIT;
        else                      r = RSN_OPEN;
        reason_o = r;
    end
endmodule

// File: rtl/egress_guard.sv
module egress_guard
    import egress_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ARM_WINDOW = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_ready,
    input  logic              fault_i,
    input  logic              selftest_i,
    input  logic              keygen_i,
    input  logic              keyload_i,
    input  logic              zeroize_i,
    input  logic              arm_a_i,
    input  logic              arm_b_i,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sens,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [2:0]        status_code
);
    typedef struct packed {
        logic seen;
    } top_t;

    top_t  top_d, top_q;
    mode_t mode;
    logic  startup;
    logic  block;
    logic  armed, arm_a_w, arm_b_w;
    logic  head_sens, fire;

    always_comb begin
        mode.fault    = fault_i;
        mode.zeroize  = zeroize_i;
        mode.selftest = selftest_i;
        mode.keygen   = keygen_i;
        mode.keyload  = keyload_i;
        startup       = !top_q.seen;
        block         = (|mode) || startup;
        top_d         = top_q;
        if (ctl_ready) begin
            top_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    egress_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .block_i      (block),
        .release_ok_i (armed),
        .in_valid_i   (in_valid),
        .in_data_i    (in_data),
        .in_sens_i    (in_sens),
        .in_ready_o   (in_ready),
        .out_ready_i  (out_ready),
        .out_valid_o  (out_valid),
        .out_data_o   (out_data),
        .head_sens_o  (head_sens),
        .fire_o       (fire)
    );

    egress_arm_ctrl #(.ARM_WINDOW(ARM_WINDOW)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (block),
        .consume_i (fire && head_sens),
        .arm_a_i   (arm_a_i),
        .arm_b_i   (arm_b_i),
        .arm_a_o   (arm_a_w),
        .arm_b_o   (arm_b_w),
        .armed_o   (armed)
    );

    egress_reason_enc u_enc (
        .mode_i     (mode),
        .startup_i  (startup),
        .arm_wait_i (head_sens && !armed),
        .reason_o   (status_code)
    );
endmodule

// File: rtl/egress_guard_chk.sv
module egress_guard_chk #(
    parameter int DATA_W     = 32,
    parameter int ARM_WINDOW = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fault_i,
    input logic              selftest_i,
    input logic              keygen_i,
    input logic              keyload_i,
    input logic              zeroize_i,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [2:0]        status_code,
    input logic              seen,
    input logic              block,
    input logic              head_sens,
    input logic              arm_a,
    input logic              arm_b
);
    int a_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_run_q <= 0;
        else if (arm_a) a_run_q <= a_run_q + 1;
        else a_run_q <= 0;
    end

    AST_FAULT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |-> (!out_valid && !in_ready && status_code == 3'd1)); // R1
    AST_SELFTEST_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_i |-> (!out_valid && !in_ready)); // R2
    AST_KEYOP_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (keygen_i || keyload_i || zeroize_i) |-> (!out_valid && !in_ready)); // R3
    AST_ZEROIZE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        (zeroize_i && !fault_i) |-> status_code == 3'd5); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data)); // R5
    AST_SENS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && head_sens) |-> (arm_a && arm_b)); // R6
    AST_B_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_b) |-> $past(arm_a)); // R6
    AST_RELEASE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && head_sens) |=> (!arm_a && !arm_b)); // R7
    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        arm_a |-> (a_run_q < ARM_WINDOW)); // R8
    AST_BLOCK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> (!arm_a && !arm_b)); // R9
    AST_STARTUP_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!in_ready && !out_valid)); // R10
    AST_OPEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> status_code == 3'd0); // R11
endmodule

bind egress_guard egress_guard_chk #(.DATA_W(DATA_W), .ARM_WINDOW(ARM_WINDOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault_i),
    .selftest_i  (selftest_i),
    .keygen_i    (keygen_i),
    .keyload_i   (keyload_i),
    .zeroize_i   (zeroize_i),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .status_code (status_code),
    .seen        (top_q.seen),
    .block       (block),
    .head_sens   (head_sens),
    .arm_a       (arm_a_w),
    .arm_b       (arm_b_w)
);

// File: tb/egress_guard_test.sv
`timescale 1ns/100ps
module egress_guard_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_ready = 1'b0;
    logic          fault_i = 1'b0, selftest_i = 1'b0, keygen_i = 1'b0;
    logic          keyload_i = 1'b0, zeroize_i = 1'b0;
    logic          arm_a_i = 1'b0, arm_b_i = 1'b0;
    logic          in_valid = 1'b0, in_sens = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid;
    logic [DW-1:0] out_data;
    logic [2:0]    status_code;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] expq[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    egress_guard uut (
        .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready),
        .fault_i(fault_i), .selftest_i(selftest_i), .keygen_i(keygen_i),
        .keyload_i(keyload_i), .zeroize_i(zeroize_i),
        .arm_a_i(arm_a_i), .arm_b_i(arm_b_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sens(in_sens),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .status_code(status_code)
    );

    function automatic logic [2:0] exp_reason(input logic f, input logic z,
                                              input logic s, input logic g, input logic k);
        if (f) return 3'd1;
        if (z) return 3'd5;
        if (s) return 3'd2;
        if (g) return 3'd3;
        if (k) return 3'd4;
        return 3'd0;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic mid;
        @(negedge clk);
    endtask

    // scoreboard monitor: accepted words in, presented words out (R5, R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk("R5 unexpected word", out_data, '1);
                end else begin
                    chk("R5 order", out_data, expq.pop_front());
                end
            end
            if (in_valid && in_ready) expq.push_back(in_data);
        end
    end

    task automatic put_word(input logic [DW-1:0] d, input logic s);
        in_valid = 1'b1; in_data = d; in_sens = s;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sens = 1'b0;
    endtask

    task automatic arm(input logic a, input logic b);
        arm_a_i = a; arm_b_i = b;
        step(1);
        arm_a_i = 1'b0; arm_b_i = 1'b0;
    endtask

    task automatic set_modes(input logic f, input logic z, input logic s,
                             input logic g, input logic k);
        fault_i = f; zeroize_i = z; selftest_i = s; keygen_i = g; keyload_i = k;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(3);
        rst_n = 1'b1;
        step(2);
        mid;
        chk("R10 status after reset", 32'(status_code), 32'd7);
        chk("R10 in_ready after reset", 32'(in_ready), 32'd0);
        chk("R10 out_valid after reset", 32'(out_valid), 32'd0);
        step(1);
        ctl_ready = 1'b1;
        step(1);
        ctl_ready = 1'b0;
        mid;
        chk("R10 released", 32'(in_ready), 32'd1);
        chk("R10 status open", 32'(status_code), 32'd0);

        // R11 pass-through, one cycle latency
        out_ready = 1'b1;
        step(1);
        in_valid = 1'b1; in_data = 32'hA5A5_0001; in_sens = 1'b0;
        step(1);
        in_valid = 1'b0;
        mid;
        chk("R11 latency valid", 32'(out_valid), 32'd1);
        chk("R11 status open", 32'(status_code), 32'd0);
        step(2);

        // R1 / R5 held word through fault
        out_ready = 1'b0;
        put_word(32'hBEEF_0002, 1'b0);
        set_modes(1, 0, 0, 0, 0);
        mid;
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 in_ready", 32'(in_ready), 32'd0);
        chk("R1 status", 32'(status_code), 32'd1);
        step(3);
        set_modes(0, 0, 0, 0, 0);
        mid;
        chk("R5 held word back", 32'(out_valid), 32'd1);
        chk("R5 held data", out_data, 32'hBEEF_0002);
        step(1);
        out_ready = 1'b1;
        step(2);

        // R2/R3 single modes, R4 combinations
        set_modes(0, 0, 1, 0, 0); mid; chk("R2 selftest", 32'(status_code), 32'd2); step(1);
        set_modes(0, 0, 0, 1, 0); mid; chk("R3 keygen", 32'(status_code), 32'd3); step(1);
        set_modes(0, 0, 0, 0, 1); mid; chk("R3 keyload", 32'(status_code), 32'd4); step(1);
        set_modes(0, 1, 0, 0, 0); mid; chk("R3 zeroize", 32'(status_code), 32'd5);
        chk("R3 in_ready", 32'(in_ready), 32'd0); step(1);
        set_modes(1, 1, 1, 1, 1); mid; chk("R4 all", 32'(status_code), 32'd1); step(1);
        set_modes(0, 1, 1, 1, 1); mid; chk("R4 zeroize over selftest", 32'(status_code), 32'd5); step(1);
        set_modes(0, 0, 1, 1, 1); mid; chk("R4 selftest over keygen", 32'(status_code), 32'd2); step(1);
        set_modes(0, 0, 0, 1, 1); mid; chk("R4 keygen over keyload", 32'(status_code), 32'd3); step(1);
        set_modes(0, 0, 0, 0, 0); step(1);

        // R6 arming order
        put_word(32'h5EC0_0003, 1'b1);
        mid;
        chk("R6 waiting status", 32'(status_code), 32'd6);
        chk("R6 not presented", 32'(out_valid), 32'd0);
        step(1);
        arm(0, 1); mid; chk("R6 B alone rejected", 32'(status_code), 32'd6); step(1);
        arm(1, 1); mid; chk("R6 both at once ignored", 32'(status_code), 32'd6); step(1);
        arm(0, 1); mid; chk("R6 B still rejected", 32'(status_code), 32'd6); step(1);
        arm(1, 0); mid; chk("R6 A only", 32'(status_code), 32'd6);
        step(1);
        arm(0, 1); mid;
        chk("R6 released", 32'(out_valid), 32'd1);
        chk("R6 data", out_data, 32'h5EC0_0003);
        step(2);

        // R7 next tagged word needs re-arm
        put_word(32'h5EC0_0004, 1'b1);
        step(2); mid;
        chk("R7 disarmed after release", 32'(status_code), 32'd6);
        step(1);

        // R8 window: inside
        arm(1, 0);
        step(248);
        arm(0, 1); mid;
        chk("R8 B inside window", 32'(out_valid), 32'd1);
        step(2);
        // R8 window: expired
        put_word(32'h5EC0_0005, 1'b1);
        arm(1, 0);
        step(260);
        arm(0, 1); mid;
        chk("R8 B after window", 32'(status_code), 32'd6);
        step(1);

        // R9 shut condition clears arm A
        arm(1, 0);
        set_modes(0, 0, 0, 1, 0); step(1);
        set_modes(0, 0, 0, 0, 0); step(1);
        arm(0, 1); mid;
        chk("R9 arm cleared by keygen", 32'(status_code), 32'd6);
        step(1);
        arm(1, 0); arm(0, 1); step(2);
        mid;
        chk("R5 tagged drained", 32'(expq.size()), 32'd0);
        step(1);

        // random phase: untagged words, toggling modes
        for (int c = 0; c < 4000; c++) begin
            logic f, z, s, g, k;
            f = ($urandom % 40) == 0;  z = ($urandom % 40) == 0;
            s = ($urandom % 30) == 0;  g = ($urandom % 30) == 0;
            k = ($urandom % 30) == 0;
            set_modes(f, z, s, g, k);
            out_ready = ($urandom % 4) != 0;
            if (!in_valid || in_ready) begin
                in_valid = ($urandom % 3) != 0;
                in_data  = $urandom;
                in_sens  = 1'b0;
            end
            mid;
            if (f | z | s | g | k) begin
                chk("R4 random status", 32'(status_code), 32'(exp_reason(f, z, s, g, k)));
                chk("R3 random shut", 32'(out_valid | in_ready), 32'd0);
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        set_modes(0, 0, 0, 0, 0);
        out_ready = 1'b1;
        step(5);
        mid;
        chk("R5 all delivered", 32'(expq.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule